// File: doc/BRIEF.md
# bfloat16 Multiply-Accumulate with Single-Precision Accumulator

This block takes a stream of bfloat16 operand pairs. For every pair that arrives with the valid strobe, it multiplies the two operands exactly. It then adds the product into a 32-bit single-precision accumulator register, rounding to nearest-even at single precision each time. The accumulator is visible on a 32-bit output. A second output presents the same accumulator rounded back to bfloat16, also to nearest-even.

Each operand is a 16-bit word. The fields are: sign in bit 15, an 8-bit biased exponent (bias 127) in bits 14..7, and a 7-bit fraction in bits 6..0. Any exponent field from 1 to 254 carries a hidden leading one. The clear input empties the accumulator to +0. Subnormal values are flushed to zero wherever they would appear. Infinities and NaNs follow the usual propagation rules, with a single default quiet NaN. A new operand pair may be presented on every clock.

Top module: `bfmac_top`

## Requirements
- R1: For operands with exponent fields 1..254, the single-precision product is exact: one accumulate from +0 leaves the exact value of a×b in the accumulator.
- R2: Each cycle with `inValid` high and `clr` low adds the product to the accumulator, rounded to nearest-even at single precision. The new value appears on `accOut` after the next rising edge, and pairs may arrive on consecutive cycles.
- R3: Reset and `clr` both load 0x00000000. `clr` wins over `inValid` in the same cycle.
- R4: With `inValid` and `clr` both low, `accOut` holds its value.
- R5: `rdOut` is `accOut` rounded to bfloat16 (upper 16 bits, decided by the lower 16) with ties to even. A finite value that rounds past 0x7F7F gives infinity (0x7F80/0xFF80), and the sign bit follows the accumulator.
- R6: An operand with exponent field 0 counts as zero. A product or sum whose biased exponent would fall below 1 becomes a zero of its own sign, so the accumulator never holds a subnormal.
- R7: A product or sum whose biased exponent would reach 255 becomes infinity of the correct sign (0x7F800000 or 0xFF800000).
- R8: Any of the following sets the accumulator to 0x7FC00000: a NaN operand (exponent 255, fraction nonzero), infinity times zero, infinities of opposite sign meeting in the add, or a NaN already in the accumulator. It stays NaN until cleared, and `rdOut` then reads 0x7FC0.
- R9: Infinity times a nonzero finite operand puts a signed infinity into the accumulator. Adding finite products to an infinite accumulator leaves it unchanged.
- R10: A sum that cancels exactly gives +0. Adding a zero product to a zero accumulator gives -0 only when both are negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Load +0 into the accumulator |
| inValid | input | 1 | Operand pair valid |
| opA | input | 16 | bfloat16 operand A |
| opB | input | 16 | bfloat16 operand B |
| accOut | output | 32 | Single-precision accumulator |
| rdOut | output | 16 | Accumulator rounded to bfloat16 |

## Verification
The bench builds the block with its defaults: 8-bit exponent, 7-bit operand fraction and 23-bit accumulator fraction. Seven fraction bits make it possible to pair every operand fraction with every other, 16384 pairs fed back to back into one running sum. The accumulator and the rounded readout are checked after every accumulate against a reference built from exact real arithmetic. Directed sequences then steer the accumulator into tie cases at both roundings, overflow, flushed underflow, signed zeros and each special-value path.

// File: rtl/bfmac_pkg.sv
package bfmac_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic zero;   // load +0
    logic accum;  // add the current product
  } macStrobe_t;
endpackage

// File: rtl/bfmac_ctrl.sv
module bfmac_ctrl (
  input  logic                  clr,
  input  logic                  inValid,
  output bfmac_pkg::macStrobe_t strobe
);
  always_comb begin
    strobe.zero  = clr;
    strobe.accum = inValid & ~clr;
  end
endmodule

// File: rtl/bfmac_rdout.sv
module bfmac_rdout #(
  parameter int EXP_W   = 8,
  parameter int OP_MAN  = 7,
  parameter int ACC_MAN = 23
) (
  input  logic [EXP_W+ACC_MAN:0] acc,
  output logic [EXP_W+OP_MAN:0]  rd
);
  localparam int OP_W   = 1 + EXP_W + OP_MAN;
  localparam int ACC_W  = 1 + EXP_W + ACC_MAN;
  localparam int DROP   = ACC_MAN - OP_MAN;
  localparam int KEEP_W = EXP_W + OP_MAN;

  logic [EXP_W-1:0]  accExp;
  logic [KEEP_W-1:0] keep;
  logic              guardBit, restBits, roundUp;

  always_comb begin
    accExp   = acc[ACC_W-2 -: EXP_W];
    keep     = acc[ACC_W-2 -: KEEP_W];
    guardBit = acc[DROP-1];
    restBits = |acc[DROP-2:0];
    roundUp  = guardBit & (restBits | keep[0]);
    if ((&accExp) && (|acc[ACC_MAN-1:0]))
      rd = {1'b0, {EXP_W{1'b1}}, 1'b1, {(OP_MAN-1){1'b0}}};
    else if ((&accExp) || (accExp == '0))
      rd = acc[ACC_W-1 -: OP_W];
    else
      rd = {acc[ACC_W-1], keep + KEEP_W'(roundUp)};  // carry into exponent yields infinity
  end
endmodule

// File: rtl/bfmac_dp.sv
module bfmac_dp #(
  parameter int EXP_W   = 8,
  parameter int OP_MAN  = 7,
  parameter int ACC_MAN = 23
) (
  input  logic                  clk,
  input  logic                  rst,
  input  bfmac_pkg::macStrobe_t strobe,
  input  logic [EXP_W+OP_MAN:0] opA,
  input  logic [EXP_W+OP_MAN:0] opB,
  output logic [EXP_W+ACC_MAN:0] accQ
);
  localparam int OP_W    = 1 + EXP_W + OP_MAN;
  localparam int ACC_W   = 1 + EXP_W + ACC_MAN;
  localparam int OP_SIG  = OP_MAN + 1;
  localparam int PROD_W  = 2 * OP_SIG;
  localparam int ACC_SIG = ACC_MAN + 1;
  localparam int PAD     = ACC_SIG - PROD_W;
  localparam int ALN_W   = ACC_SIG + 3;
  localparam int EXT_W   = EXP_W + 3;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int EMAX    = (1 << EXP_W) - 1;
  localparam logic signed [EXT_W-1:0] ONE_E = EXT_W'(1);
  localparam logic signed [EXT_W-1:0] MAX_E = EXT_W'(EMAX);
  localparam logic [ACC_W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(ACC_MAN-1){1'b0}}};

  // ---------------- operand decode ----------------
  logic [OP_W-1:0]   ops    [2];
  logic [EXP_W-1:0]  opExp  [2];
  logic [OP_SIG-1:0] opSig  [2];
  logic [1:0]        opSgn, opZero, opInf, opNan;

  assign ops[0] = opA;
  assign ops[1] = opB;

  for (genvar k = 0; k < 2; k++) begin : g_dec
    assign opSgn[k]  = ops[k][OP_W-1];
    assign opExp[k]  = ops[k][OP_W-2 -: EXP_W];
    assign opSig[k]  = {1'b1, ops[k][OP_MAN-1:0]};
    assign opZero[k] = (opExp[k] == '0);
    assign opInf[k]  = (&opExp[k]) && (ops[k][OP_MAN-1:0] == '0);
    assign opNan[k]  = (&opExp[k]) && (|ops[k][OP_MAN-1:0]);
  end

  // ---------------- exact product ----------------
  logic [PROD_W-1:0]        sigProd;
  logic signed [EXT_W-1:0]  pExpRaw;
  logic [EXP_W-1:0]         pExp;
  logic [ACC_SIG-1:0]       pSig;
  logic                     pSgn, pNan, pInf, pZero, pFinite;

  always_comb begin
    sigProd = PROD_W'(opSig[0]) * PROD_W'(opSig[1]);
    pSgn    = opSgn[0] ^ opSgn[1];
    pExpRaw = EXT_W'(opExp[0]) + EXT_W'(opExp[1]) - EXT_W'(BIAS)
              + EXT_W'(sigProd[PROD_W-1]);
    pExp    = pExpRaw[EXP_W-1:0];
    if (sigProd[PROD_W-1]) pSig = {sigProd, {PAD{1'b0}}};
    else                   pSig = {sigProd[PROD_W-2:0], {(PAD+1){1'b0}}};
    pNan    = (|opNan) | (opInf[0] & opZero[1]) | (opZero[0] & opInf[1]);
    pFinite = ~pNan & ~(|opInf) & ~(|opZero);
    pInf    = ~pNan & ((|opInf) | (pFinite & (pExpRaw >= MAX_E)));
    pZero   = ~pNan & ~(|opInf) & ((|opZero) | (pExpRaw < ONE_E));
  end

  // ---------------- accumulator decode ----------------
  logic [EXP_W-1:0]   cExp;
  logic [ACC_SIG-1:0] cSig;
  logic               cSgn, cZero, cInf, cNan;

  always_comb begin
    cSgn  = accQ[ACC_W-1];
    cExp  = accQ[ACC_W-2 -: EXP_W];
    cSig  = {1'b1, accQ[ACC_MAN-1:0]};
    cZero = (cExp == '0);
    cInf  = (&cExp) && (accQ[ACC_MAN-1:0] == '0);
    cNan  = (&cExp) && (|accQ[ACC_MAN-1:0]);
  end

  // ---------------- finite addition ----------------
  logic                    pBig, bSgn, effSub, guardBit, rndBit, stkBit, roundUp, found;
  logic [EXP_W-1:0]        bExp, sExp, expDiff;
  logic [ACC_SIG-1:0]      bSig, sSig, keep;
  logic [2*ALN_W-1:0]      wide;
  logic [ALN_W-1:0]        sAl, bAl, nSig;
  logic [ALN_W:0]          rawSum;
  logic [ACC_SIG:0]        rnd;
  logic signed [EXT_W-1:0] sumExp;
  logic [ACC_W-1:0]        sumPacked;
  int                      shAmt, lz;

  always_comb begin
    pBig    = {pExp, pSig} > {cExp, cSig};
    bSgn    = pBig ? pSgn : cSgn;
    bExp    = pBig ? pExp : cExp;
    bSig    = pBig ? pSig : cSig;
    sExp    = pBig ? cExp : pExp;
    sSig    = pBig ? cSig : pSig;
    expDiff = bExp - sExp;
    shAmt   = (int'(expDiff) > ALN_W) ? ALN_W : int'(expDiff);
    wide    = {sSig, 3'b000, {ALN_W{1'b0}}} >> shAmt;
    sAl     = wide[2*ALN_W-1:ALN_W];
    sAl[0]  = sAl[0] | (|wide[ALN_W-1:0]);  // sticky
    bAl     = {bSig, 3'b000};
    effSub  = pSgn ^ cSgn;
    rawSum  = effSub ? ({1'b0, bAl} - {1'b0, sAl}) : ({1'b0, bAl} + {1'b0, sAl});
    sumExp  = EXT_W'(bExp);
    lz      = 0;
    found   = 1'b0;
    for (int i = ALN_W - 1; i >= 0; i--) begin
      if (!found) begin
        if (rawSum[i]) found = 1'b1;
        else           lz = lz + 1;
      end
    end
    if (rawSum[ALN_W]) begin
      nSig   = {rawSum[ALN_W:2], rawSum[1] | rawSum[0]};
      sumExp = sumExp + ONE_E;
    end else begin
      nSig   = rawSum[ALN_W-1:0] << lz;
      sumExp = sumExp - EXT_W'(lz);
    end
    keep     = nSig[ALN_W-1:3];
    guardBit = nSig[2];
    rndBit   = nSig[1];
    stkBit   = nSig[0];
    roundUp  = guardBit & (rndBit | stkBit | keep[0]);
    rnd      = {1'b0, keep} + {{ACC_SIG{1'b0}}, roundUp};
    if (rnd[ACC_SIG]) sumExp = sumExp + ONE_E;
    if (rawSum == '0)
      sumPacked = '0;                                   // exact cancellation
    else if (sumExp >= MAX_E)
      sumPacked = {bSgn, {EXP_W{1'b1}}, {ACC_MAN{1'b0}}};
    else if (sumExp < ONE_E)
      sumPacked = {bSgn, {(ACC_W-1){1'b0}}};            // flushed underflow
    else
      sumPacked = {bSgn, sumExp[EXP_W-1:0], rnd[ACC_MAN-1:0]};
  end

  // ---------------- special-case selection ----------------
  logic [ACC_W-1:0] nextAcc;

  always_comb begin
    if (pNan | cNan | (pInf & cInf & (pSgn ^ cSgn)))
      nextAcc = QNAN;
    else if (pInf)
      nextAcc = {pSgn, {EXP_W{1'b1}}, {ACC_MAN{1'b0}}};
    else if (cInf)
      nextAcc = accQ;
    else if (pZero & cZero)
      nextAcc = {pSgn & cSgn, {(ACC_W-1){1'b0}}};
    else if (pZero)
      nextAcc = accQ;
    else if (cZero)
      nextAcc = {pSgn, pExp, pSig[ACC_MAN-1:0]};
    else
      nextAcc = sumPacked;
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.zero) accQ <= '0;
    else if (strobe.accum)  accQ <= nextAcc;
  end

  // R4
  holdIdle_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobe.zero && !strobe.accum) |=> $stable(accQ));
  // R6
  noSubnormal_chk: assert property (@(posedge clk) disable iff (rst)
    (accQ[ACC_W-2 -: EXP_W] == '0) |-> (accQ[ACC_MAN-1:0] == '0));
  // R8
  nanSticky_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.accum && cNan) |=> (accQ == QNAN));
  // R8
  nanOperand_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.accum && (|opNan)) |=> (accQ == QNAN));
endmodule

// File: rtl/bfmac_top.sv
module bfmac_top #(
  parameter int EXP_W   = 8,
  parameter int OP_MAN  = 7,
  parameter int ACC_MAN = 23
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr,
  input  logic                   inValid,
  input  logic [EXP_W+OP_MAN:0]  opA,
  input  logic [EXP_W+OP_MAN:0]  opB,
  output logic [EXP_W+ACC_MAN:0] accOut,
  output logic [EXP_W+OP_MAN:0]  rdOut
);
  localparam int OP_W  = 1 + EXP_W + OP_MAN;
  localparam int ACC_W = 1 + EXP_W + ACC_MAN;
  localparam logic [OP_W-1:0] RD_QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(OP_MAN-1){1'b0}}};

  bfmac_pkg::macStrobe_t strobe;

  bfmac_ctrl u_ctrl (.clr(clr), .inValid(inValid), .strobe(strobe));

  bfmac_dp #(.EXP_W(EXP_W), .OP_MAN(OP_MAN), .ACC_MAN(ACC_MAN)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .opA(opA), .opB(opB), .accQ(accOut));

  bfmac_rdout #(.EXP_W(EXP_W), .OP_MAN(OP_MAN), .ACC_MAN(ACC_MAN)) u_rd (
    .acc(accOut), .rd(rdOut));

  logic accNan;
  assign accNan = (&accOut[ACC_W-2 -: EXP_W]) && (|accOut[ACC_MAN-1:0]);

  // R3
  clrPort_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (accOut == '0));
  // R8
  nanRead_chk: assert property (@(posedge clk) disable iff (rst)
    accNan |-> (rdOut == RD_QNAN));
  // R5
  rdSign_chk: assert property (@(posedge clk) disable iff (rst)
    !accNan |-> (rdOut[OP_W-1] == accOut[ACC_W-1]));
endmodule

// File: tb/tb_bfmac_top.sv
`timescale 1ns/100ps
module tb_bfmac_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic [31:0] accOut;
  logic [15:0] rdOut;

  int checkCount = 0;
  int failCount  = 0;
  bit done = 1'b0;

  bfmac_top dut (.clk(clk), .rst(rst), .clr(clr), .inValid(inValid),
                 .opA(opA), .opB(opB), .accOut(accOut), .rdOut(rdOut));

  always #2.5 clk = ~clk;

  function automatic real pow2(input int n);
    real r = 1.0;
    if (n >= 0) for (int i = 0; i < n; i++) r = r * 2.0;
    else        for (int i = 0; i < -n; i++) r = r / 2.0;
    return r;
  endfunction

  function automatic real bfToReal(input logic [15:0] v);
    real m;
    if (v[14:7] == 8'd0) return 0.0;
    m = 1.0 + real'(v[6:0]) / 128.0;
    m = m * pow2(int'(v[14:7]) - 127);
    return v[15] ? -m : m;
  endfunction

  function automatic real f32ToReal(input logic [31:0] v);
    real m;
    if (v[30:23] == 8'd0) return 0.0;
    m = 1.0 + real'(v[22:0]) / 8388608.0;
    m = m * pow2(int'(v[30:23]) - 127);
    return v[31] ? -m : m;
  endfunction

  // nearest-even rounding of a normal-range real to single precision
  function automatic logic [31:0] realToF32(input real x);
    logic [63:0] b;
    logic [30:0] keep;
    int          e;
    logic        up;
    b = $realtobits(x);
    if (b[62:52] == 11'd0) return {b[63], 31'd0};
    e    = int'(b[62:52]) - 1023 + 127;
    keep = {e[7:0], b[51:29]};
    up   = b[28] & ((|b[27:0]) | keep[0]);
    return {b[63], keep + 31'(up)};
  endfunction

  function automatic logic [15:0] f32ToBf(input logic [31:0] v);
    logic [14:0] keep;
    logic        up;
    if ((&v[30:23]) && (|v[22:0])) return 16'h7FC0;
    if ((&v[30:23]) || (v[30:23] == 8'd0)) return v[31:16];
    keep = v[30:16];
    up   = v[15] & ((|v[14:0]) | keep[0]);
    return {v[31], keep + 15'(up)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] expv);
    checkCount++;
    if (got !== expv) begin
      failCount++;
      $display("FAIL %s: got %h expected %h", tag, got, expv);
    end
  endtask

  // drive at a falling edge, return at the next falling edge
  task automatic cyc(input logic c, input logic v, input logic [15:0] a, input logic [15:0] b);
    clr = c; inValid = v; opA = a; opB = b;
    @(negedge clk);
    clr = 1'b0; inValid = 1'b0;
  endtask

  task automatic acc1(input logic [15:0] a, input logic [15:0] b);
    cyc(1'b0, 1'b1, a, b);
  endtask

  task automatic clear();
    cyc(1'b1, 1'b0, 16'h0, 16'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    logic [31:0] expAcc;
    logic [15:0] a, b;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R3 reset accOut", accOut, 32'h0);
    chk("R3 reset rdOut", {16'h0, rdOut}, 32'h0);

    // R1 R2 R5: every fraction pair, back to back, running sum
    expAcc = 32'h0;
    for (int i = 0; i < 128; i++) begin
      for (int j = 0; j < 128; j++) begin
        a = {i[0], 8'(126 + (i % 3)), i[6:0]};
        b = {j[0] ^ j[3], 8'(125 + (j % 4)), j[6:0]};
        acc1(a, b);
        expAcc = realToF32(f32ToReal(expAcc) + bfToReal(a) * bfToReal(b));
        chk("R2 sweep accOut", accOut, expAcc);
        chk("R5 sweep rdOut", {16'h0, rdOut}, {16'h0, f32ToBf(expAcc)});
      end
    end

    // R1 single exact products
    clear();
    acc1(16'h3F80, 16'h3F80);
    chk("R1 one times one", accOut, 32'h3F800000);
    clear();
    acc1(16'h3FFF, 16'hBFFF);
    chk("R1 widest product", accOut, realToF32(bfToReal(16'h3FFF) * bfToReal(16'hBFFF)));

    // R3 clear wins over valid
    acc1(16'h3F80, 16'h3F80);
    cyc(1'b1, 1'b1, 16'h3F80, 16'h3F80);
    chk("R3 clear priority", accOut, 32'h0);

    // R4 idle holds
    acc1(16'h4000, 16'h3F80);
    cyc(1'b0, 1'b0, 16'h4000, 16'h4000);
    chk("R4 idle hold", accOut, 32'h40000000);

    // R2 single-precision ties
    clear();
    acc1(16'h3F80, 16'h3F80);
    acc1(16'h3380, 16'h3F80);
    chk("R2 tie to even down", accOut, 32'h3F800000);
    acc1(16'h3400, 16'h3F80);
    chk("R2 exact lsb", accOut, 32'h3F800001);
    acc1(16'h3380, 16'h3F80);
    chk("R2 tie to even up", accOut, 32'h3F800002);

    // R5 readout rounding
    clear();
    acc1(16'h3F80, 16'h3F80);
    acc1(16'h3B80, 16'h3F80);
    chk("R5 acc value", accOut, 32'h3F808000);
    chk("R5 tie even down", {16'h0, rdOut}, 32'h3F80);
    acc1(16'h3B00, 16'h3F80);
    chk("R5 above half", {16'h0, rdOut}, 32'h3F81);
    clear();
    acc1(16'h3F80, 16'h3F80);
    acc1(16'h3C00, 16'h3F80);
    acc1(16'h3B80, 16'h3F80);
    chk("R5 tie odd up", {16'h0, rdOut}, 32'h3F82);
    clear();
    acc1(16'h7F7F, 16'h3F80);
    acc1(16'h7B00, 16'h3F80);
    chk("R5 acc near max", accOut, 32'h7F7F8000);
    chk("R5 round to inf", {16'h0, rdOut}, 32'h7F80);

    // R7 overflow
    clear();
    acc1(16'h7F7F, 16'h7F7F);
    chk("R7 product overflow", accOut, 32'h7F800000);
    clear();
    acc1(16'hFF7F, 16'h7F7F);
    chk("R7 negative overflow", accOut, 32'hFF800000);
    clear();
    acc1(16'h7F7F, 16'h3F80);
    acc1(16'h7F7F, 16'h3F80);
    chk("R7 sum overflow", accOut, 32'h7F800000);
    chk("R5 inf readout", {16'h0, rdOut}, 32'h7F80);

    // R8 NaN paths
    clear();
    acc1(16'h7FC1, 16'h3F80);
    chk("R8 nan operand", accOut, 32'h7FC00000);
    chk("R8 nan readout", {16'h0, rdOut}, 32'h7FC0);
    acc1(16'h3F80, 16'h3F80);
    chk("R8 nan sticky", accOut, 32'h7FC00000);
    clear();
    chk("R8 cleared", accOut, 32'h0);
    acc1(16'h7F80, 16'h0000);
    chk("R8 inf times zero", accOut, 32'h7FC00000);
    clear();
    acc1(16'h7F80, 16'h3F80);
    chk("R9 inf product", accOut, 32'h7F800000);
    acc1(16'hFF80, 16'h3F80);
    chk("R8 inf minus inf", accOut, 32'h7FC00000);

    // R9 infinities
    clear();
    acc1(16'hFF80, 16'h4000);
    chk("R9 neg inf", accOut, 32'hFF800000);
    chk("R9 neg inf readout", {16'h0, rdOut}, 32'hFF80);
    acc1(16'h3F80, 16'h3F80);
    chk("R9 inf absorbs", accOut, 32'hFF800000);

    // R6 flush to zero
    clear();
    acc1(16'h3F80, 16'h3F80);
    acc1(16'h0001, 16'h3F80);
    chk("R6 subnormal operand", accOut, 32'h3F800000);
    acc1(16'h007F, 16'h7F00);
    chk("R6 subnormal operand big", accOut, 32'h3F800000);
    clear();
    acc1(16'h0080, 16'h3F00);
    chk("R6 subnormal product", accOut, 32'h0);
    clear();
    acc1(16'h80C0, 16'h3F80);
    chk("R6 tiny normal", accOut, 32'h80C00000);
    acc1(16'h0080, 16'h3F80);
    chk("R6 subnormal sum", accOut, 32'h80000000);
    chk("R10 neg zero readout", {16'h0, rdOut}, 32'h8000);

    // R10 zero signs
    acc1(16'h8000, 16'h3F80);
    chk("R10 neg plus neg zero", accOut, 32'h80000000);
    acc1(16'h0000, 16'h3F80);
    chk("R10 neg plus pos zero", accOut, 32'h0);
    clear();
    acc1(16'h3F80, 16'h3F80);
    acc1(16'hBF80, 16'h3F80);
    chk("R10 exact cancel", accOut, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end
endmodule